// File: doc/BRIEF.md
# Two-Wire Serial Clock Generator

This block produces the serial clock for the master side of a two-wire bus. A bit-rate byte and a two-bit prescale code set the length of each clock half: a half lasts `8 + bit_rate × factor` source ticks, where the factor is 1, 4, 16 or 64. A full clock period is therefore `16 + 2 × bit_rate × factor` source ticks. In high-speed mode the source tick is every system clock cycle. In normal mode the source is the system clock divided by the parameter `NORM_DIV`.

The block does not drive the bus pin directly. It reports through `scl_low` whether the open-drain clock line should be pulled low, and `scl_tick` pulses once at the start of every phase. The settings are sampled only when a low phase begins, so software may rewrite them while a clock is running. A bit-rate below `MIN_RATE` (10 by default) is refused: the block raises `rate_err`, leaves the line released and produces no clock until a legal value appears or the master is disabled.

The controller has four states. `ST_IDLE` means disabled. `ST_LOW` and `ST_HIGH` are the two clock halves. `ST_FAULT` means enabled with an illegal rate. The transitions are:
- `ST_IDLE` goes to `ST_LOW` on enable with a legal rate, and to `ST_FAULT` on enable with an illegal rate.
- `ST_LOW` goes to `ST_HIGH` when its count expires.
- `ST_HIGH` goes to `ST_LOW` when its count expires with a legal rate, and to `ST_FAULT` when it expires with an illegal rate.
- `ST_FAULT` goes to `ST_LOW` once the rate becomes legal.
- Every state goes to `ST_IDLE` when enable drops.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_low`, `scl_tick` and `rate_err` are all 0.
- R2: In high-speed mode (`hs_mode`=1), each low phase and each high phase lasts `8 + bit_rate × F` system cycles. F is 1, 4, 16 or 64 for `pre_sel` codes 0, 1, 2 and 3.
- R3: In normal mode (`hs_mode`=0), each phase lasts `NORM_DIV × (8 + bit_rate × F)` system cycles, with F encoded as in R2.
- R4: After an enable with a legal rate, a low phase starts one cycle later. Low and high phases then alternate, and `scl_tick` is 1 for exactly the first cycle of each phase.
- R5: While enabled with `bit_rate` below 10, `rate_err` is 1 from the next cycle on, `scl_low` stays 0 and no `scl_tick` appears.
- R6: When a legal `bit_rate` is applied during the error condition, the error clears and a low phase starts on the next cycle.
- R7: Changes to `bit_rate`, `pre_sel` or `hs_mode` during a phase affect neither that phase nor the following high phase. They take effect from the next low phase.
- R8: Dropping `enable` releases the line (`scl_low`=0) on the next cycle and clears the phase count. A later enable starts a full-length low phase.
- R9: If `bit_rate` is illegal when a high phase ends, no new low phase begins and `rate_err` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master clock generation enable |
| hs_mode | input | 1 | 1 selects the undivided system clock as source |
| bit_rate | input | RATE_W | Bit-rate value |
| pre_sel | input | PS_W | Prescale code (0..3 gives factor 1, 4, 16, 64) |
| scl_low | output | 1 | 1 = pull the clock line low, 0 = release it |
| scl_tick | output | 1 | One-cycle strobe at the start of each phase |
| rate_err | output | 1 | Enabled with an illegal bit-rate |

## Verification
The bench builds the block with its default parameters: an 8-bit rate, a 2-bit prescale code, `MIN_RATE` of 10 and `NORM_DIV` of 2. A `NORM_DIV` of 2 makes the normal-mode source clearly differ from the high-speed source, while keeping every phase short enough to measure cycle by cycle. Random rates between 10 and 60 with prescale codes 0 to 2 keep each phase under two thousand cycles. The largest factor is exercised once at the smallest legal rate, and the boundary at 9 versus 10 is driven directly.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_FAULT = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_period_calc.sv
module scl_period_calc #(
    parameter int RATE_W   = 8,
    parameter int PS_W     = 2,
    parameter int NORM_DIV = 2,
    parameter int MIN_RATE = 10,
    parameter int LEN_W    = 17
) (
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [PS_W-1:0]   pre_sel,
    input  logic              hs_mode,
    output logic [LEN_W-1:0]  phase_len,
    output logic              rate_ok
);

    logic [LEN_W-1:0] factor;
    logic [LEN_W-1:0] half_ticks;

    always_comb begin
        // factor = 4 ** pre_sel
        factor     = LEN_W'(1) << (2 * pre_sel);
        half_ticks = LEN_W'(8) + LEN_W'(bit_rate) * factor;
        rate_ok    = (32'(bit_rate) >= MIN_RATE);
    end

    generate
        if (NORM_DIV == 1) begin : g_no_div
            assign phase_len = half_ticks;
        end else begin : g_div
            assign phase_len = hs_mode ? half_ticks : half_ticks * LEN_W'(NORM_DIV);
        end
    endgenerate

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LEN_W-1:0] limit,
    output logic             done
);

    logic [LEN_W-1:0] cnt;

    assign done = run && (cnt == limit - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int RATE_W   = 8,
    parameter int PS_W     = 2,
    parameter int NORM_DIV = 2,
    parameter int MIN_RATE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_mode,
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [PS_W-1:0]   pre_sel,
    output logic              scl_low,
    output logic              scl_tick,
    output logic              rate_err
);

    localparam int MAX_SHIFT = 2 * ((1 << PS_W) - 1);
    localparam int LEN_W     = RATE_W + MAX_SHIFT + $clog2(NORM_DIV + 1) + 1;

    scl_state_e       state, nxt;
    logic [LEN_W-1:0] new_len;
    logic [LEN_W-1:0] len_q;
    logic             rate_ok;
    logic             phase_done;
    logic             phase_run;
    logic             tick_q;

    scl_period_calc #(
        .RATE_W  (RATE_W),
        .PS_W    (PS_W),
        .NORM_DIV(NORM_DIV),
        .MIN_RATE(MIN_RATE),
        .LEN_W   (LEN_W)
    ) u_calc (
        .bit_rate (bit_rate),
        .pre_sel  (pre_sel),
        .hs_mode  (hs_mode),
        .phase_len(new_len),
        .rate_ok  (rate_ok)
    );

    assign phase_run = (state == ST_LOW) || (state == ST_HIGH);

    scl_phase_cnt #(
        .LEN_W(LEN_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(!enable),
        .run  (phase_run),
        .limit(len_q),
        .done (phase_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (enable) nxt = rate_ok ? ST_LOW : ST_FAULT;
            end
            ST_LOW: begin
                if (!enable)         nxt = ST_IDLE;
                else if (phase_done) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (!enable)         nxt = ST_IDLE;
                else if (phase_done) nxt = rate_ok ? ST_LOW : ST_FAULT;
            end
            ST_FAULT: begin
                if (!enable)      nxt = ST_IDLE;
                else if (rate_ok) nxt = ST_LOW;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            len_q  <= LEN_W'(8);
            tick_q <= 1'b0;
        end else begin
            state  <= nxt;
            tick_q <= (nxt != state) && ((nxt == ST_LOW) || (nxt == ST_HIGH));
            if ((nxt == ST_LOW) && (state != ST_LOW)) begin
                len_q <= new_len;
            end
        end
    end

    always_comb begin
        scl_low  = (state == ST_LOW);
        rate_err = (state == ST_FAULT);
        scl_tick = tick_q;
    end

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int RATE_W   = 8,
    parameter int PS_W     = 2,
    parameter int MIN_RATE = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              hs_mode,
    input logic [RATE_W-1:0] bit_rate,
    input logic [PS_W-1:0]   pre_sel,
    input logic              scl_low,
    input logic              scl_tick,
    input logic              rate_err
);

    // R5
    fault_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> !scl_low);

    // R4
    low_start_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> scl_tick);

    // R4
    tick_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> (scl_low != $past(scl_low)));

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_low && !rate_err && !scl_tick));

    // R6
    legal_low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> (32'($past(bit_rate)) >= MIN_RATE));

    // R5
    err_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> $past(enable));

endmodule

bind scl_clkgen scl_clkgen_chk #(
    .RATE_W  (RATE_W),
    .PS_W    (PS_W),
    .MIN_RATE(MIN_RATE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .hs_mode (hs_mode),
    .bit_rate(bit_rate),
    .pre_sel (pre_sel),
    .scl_low (scl_low),
    .scl_tick(scl_tick),
    .rate_err(rate_err)
);

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;

    localparam int NDIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       hs_mode = 1'b1;
    logic [7:0] bit_rate = 8'd10;
    logic [1:0] pre_sel = 2'd0;
    logic       scl_low, scl_tick, rate_err;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    scl_clkgen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hs_mode(hs_mode),
        .bit_rate(bit_rate), .pre_sel(pre_sel),
        .scl_low(scl_low), .scl_tick(scl_tick), .rate_err(rate_err)
    );

    function automatic int exp_len(int br, int ps, bit hs);
        int h;
        h = 8 + br * (1 << (2 * ps));
        return hs ? h : h * NDIV;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge where scl_tick was seen; returns at the next tick.
    task automatic measure(output int len, output bit lowv);
        len  = 1;
        lowv = scl_low;
        forever begin
            @(negedge clk);
            if (scl_tick) break;
            len++;
        end
    endtask

    task automatic start_clock(int br, int ps, bit hs);
        enable = 1'b0;
        @(negedge clk);
        bit_rate = 8'(br);
        pre_sel  = 2'(ps);
        hs_mode  = hs;
        enable   = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_pair(int br, int ps, bit hs, string req);
        int len;
        bit lv;
        start_clock(br, ps, hs);
        check(scl_tick && scl_low, "R4 low start", {scl_tick, scl_low}, 3);
        measure(len, lv);
        check(len == exp_len(br, ps, hs), req, len, exp_len(br, ps, hs));
        check(lv == 1'b1, "R4 first phase low", lv, 1);
        measure(len, lv);
        check(len == exp_len(br, ps, hs), req, len, exp_len(br, ps, hs));
        check(lv == 1'b0, "R4 second phase high", lv, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        bit lv;
        int viol;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_low && !scl_tick && !rate_err, "R1 reset",
              {scl_low, scl_tick, rate_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_low && !scl_tick && !rate_err, "R1 after release",
              {scl_low, scl_tick, rate_err}, 0);

        // R2 high-speed, codes 0 and 3
        run_pair(10, 0, 1'b1, "R2 hs code0");
        run_pair(10, 3, 1'b1, "R2 hs code3");
        run_pair(17, 1, 1'b1, "R2 hs code1");
        // R3 normal mode
        run_pair(10, 1, 1'b0, "R3 normal code1");
        run_pair(12, 2, 1'b0, "R3 normal code2");

        // R7 settings change mid-phase
        start_clock(20, 0, 1'b1);
        bit_rate = 8'd30;
        hs_mode  = 1'b0;
        measure(len, lv);
        check(len == 28, "R7 current low keeps old", len, 28);
        measure(len, lv);
        check(len == 28, "R7 high keeps old", len, 28);
        measure(len, lv);
        check(len == exp_len(30, 0, 1'b0), "R7 next low uses new", len, exp_len(30, 0, 1'b0));

        // R8 disable mid-phase
        start_clock(15, 0, 1'b1);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_low && !scl_tick, "R8 released after disable", {scl_low, scl_tick}, 0);
        repeat (3) @(negedge clk);
        check(!scl_low && !rate_err, "R8 stays released", {scl_low, rate_err}, 0);
        enable = 1'b1;
        @(negedge clk);
        check(scl_tick && scl_low, "R8 restart tick", {scl_tick, scl_low}, 3);
        measure(len, lv);
        check(len == 23, "R8 full low after restart", len, 23);

        // R5 illegal rate (9 is the boundary)
        start_clock(9, 0, 1'b1);
        check(rate_err && !scl_low, "R5 err raised", {rate_err, scl_low}, 2);
        viol = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_low || scl_tick || !rate_err) viol++;
        end
        check(viol == 0, "R5 no clock while illegal", viol, 0);
        // R6 recovery at the boundary value 10
        bit_rate = 8'd10;
        @(negedge clk);
        check(scl_tick && scl_low && !rate_err, "R6 recover",
              {scl_tick, scl_low, rate_err}, 6);
        measure(len, lv);
        check(len == 18, "R6 low length after recovery", len, 18);

        // R9 illegal value at end of high phase
        bit_rate = 8'd5;
        repeat (17) @(negedge clk);
        check(!scl_low && !rate_err, "R9 still high", {scl_low, rate_err}, 0);
        @(negedge clk);
        check(rate_err && !scl_low && !scl_tick, "R9 fault after high",
              {rate_err, scl_low, scl_tick}, 4);

        // Random trials, R2 and R3
        for (int t = 0; t < 12; t++) begin
            int br;
            int ps;
            bit hs;
            br = 10 + int'($urandom % 51);
            ps = int'($urandom % 3);
            hs = 1'($urandom % 2);
            run_pair(br, ps, hs, hs ? "R2 random" : "R3 random");
        end

        enable = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule